// File: doc/BRIEF.md
# Interrupt Move Command Executor

This block carries out one "move a translated interrupt to another collection" command from a command queue in memory. After a start pulse it reads the three command doublewords, one at a time, through a single memory port. It then looks up the device table entry, the translation entry for the event, and the collection entries for the old and the new collection. It checks every field in a fixed order. The first check that fails ends the command as CONTINUE. That command writes nothing and moves nothing, and the block raises a one-cycle error strobe that carries a reason code.

When every check passes, the block compares the target processor of the old collection with that of the new one. If they differ, it sends a one-cycle move request (old target, new target, interrupt ID) to the redistributor side. In both cases it then writes the translation entry back with the new collection ID. A memory error on any read or write ends the command as STALL, which tells the queue logic to keep its read pointer where it is.

Memory layout used by the block (64-bit words, byte addresses):
- Command word 0: device ID in [63:32]. Command word 1: event ID in [31:0]. Command word 2: new collection ID in [15:0].
- Device entry: valid in [0], SIZE in [5:1], translation table base address in [63:32].
- Translation entry: valid in [0], physical type in [1], interrupt ID in [17:2], doorbell in [33:18], collection ID in [49:34].
- Collection entry: valid in [0], target processor in [16:1].

Top module: `intr_move_exec`

## Requirements
- R1: The command words are read at cmd_base+cmd_off, +8 and +16. The device ID comes from word 0 [63:32], the event ID from word 1 [31:0] and the new collection ID from word 2 [15:0]. The device entry is read at dev_base+8*device ID, the translation entry at its table base+8*event ID, and each collection entry at coll_base+8*collection ID.
- R2: A memory access that returns mem_err ends the command with done=1 and stall=1. No later memory access is made. A failed write leaves the entry as it was.
- R3: A device ID that is not below dev_entries rejects the command with reason 1. A device entry whose valid bit [0] is clear rejects it with reason 2.
- R4: An event ID at or above 2^(SIZE+1), with SIZE taken from the device entry [5:1], rejects the command with reason 3. An event ID of 2^(SIZE+1)-1 is accepted.
- R5: A translation entry whose valid bit is clear gives reason 4. An old collection ID (entry [49:34]) that is not below coll_entries gives reason 5. A new collection ID that is not below coll_entries gives reason 6.
- R6: An old collection entry that is not valid gives reason 7, and a new one that is not valid gives reason 8. An old target that is not below cpu_count gives reason 9, and a new target that is not below cpu_count gives reason 10.
- R7: The checks run in the order of the reason codes 1 to 10. Only the first failing check is reported.
- R8: A rejected command ends with done=1, stall=0 and err_valid=1 in the same cycle. It makes no memory write and no move request.
- R9: When the two targets differ, mv_valid pulses for one cycle with mv_from=old target, mv_to=new target and mv_intid=the entry's interrupt ID, before the write-back.
- R10: When the two targets are equal, no move request is made, but the entry is still written back.
- R11: The written entry holds valid=1, physical=1, the same interrupt ID, doorbell 1023 and the new collection ID, with bits [63:50] zero.
- R12: done is a one-cycle pulse. stall is 0 for CONTINUE and 1 for STALL.
- R13: Only one memory request is open at a time. mem_req, mem_we and mem_addr stay stable until mem_ack.
- R14: After reset, done, err_valid, mv_valid and mem_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin one command |
| cmd_base | input | AW | Command queue base address |
| cmd_off | input | AW | Byte offset of the command in the queue |
| dev_base | input | AW | Device table base |
| coll_base | input | AW | Collection table base |
| dev_entries | input | 32 | Number of device table entries |
| coll_entries | input | CIDW+1 | Number of collection table entries |
| cpu_count | input | PNW+1 | Number of processors |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Request byte address |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Request completed |
| mem_err | input | 1 | Request failed (with mem_ack) |
| mem_rdata | input | 64 | Read data (with mem_ack) |
| mv_valid | output | 1 | Move request strobe |
| mv_from | output | PNW | Old target processor |
| mv_to | output | PNW | New target processor |
| mv_intid | output | INTW | Interrupt to move |
| done | output | 1 | Command finished |
| stall | output | 1 | Result: 0 continue, 1 stall |
| err_valid | output | 1 | Command rejected strobe |
| err_code | output | 4 | Reason code 1..10 |

## Verification
The bench targets the edges of every range check: device ID equal to dev_entries, and event ID at 2^(SIZE+1) and one below it. A design with an off-by-one comparison would either accept a command that does not exist or reject a legal one.

Commands with two faults at once check that the earliest reason wins. A design that evaluates the checks in parallel would report the wrong code. A command placed at a nonzero queue offset, with a trap entry at offset zero, exposes address arithmetic that ignores the offset.

Memory errors are injected on a command word, on a table read and on the final write. Each must give STALL, and the failed write must leave memory untouched. Equal targets must still rewrite the entry without raising a move, so that a design that skips the write-back or always moves is caught.

// File: rtl/intr_move_exec.sv
module intr_move_exec #(
  parameter int AW   = 32,
  parameter int CIDW = 16,
  parameter int INTW = 16,
  parameter int PNW  = 16,
  parameter int SPUR = 1023
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   cmd_base,
  input  logic [AW-1:0]   cmd_off,
  input  logic [AW-1:0]   dev_base,
  input  logic [AW-1:0]   coll_base,
  input  logic [31:0]     dev_entries,
  input  logic [CIDW:0]   coll_entries,
  input  logic [PNW:0]    cpu_count,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [63:0]     mem_wdata,
  input  logic            mem_ack,
  input  logic            mem_err,
  input  logic [63:0]     mem_rdata,
  output logic            mv_valid,
  output logic [PNW-1:0]  mv_from,
  output logic [PNW-1:0]  mv_to,
  output logic [INTW-1:0] mv_intid,
  output logic            done,
  output logic            stall,
  output logic            err_valid,
  output logic [3:0]      err_code
);
  localparam int IC_LO = 2*INTW + 2;
  localparam logic [INTW-1:0] SPUR_ID = INTW'(SPUR);

  typedef enum logic [1:0] {S_IDLE, S_MEM, S_EVAL} st_t;
  st_t st;
  logic [2:0] step;

  logic [31:0]     devid, evid;
  logic [CIDW-1:0] nicid, oicid;
  logic            dte_v, ite_v, octe_v, ncte_v;
  logic [4:0]      dte_size;
  logic [AW-1:0]   itt_base;
  logic [INTW-1:0] intid;
  logic [PNW-1:0]  otgt, ntgt;
  logic [3:0]      code;

  wire unused_rd = ^mem_rdata;

  wire [5:0]    ev_shift = {1'b0, dte_size} + 6'd1;
  wire          ev_bad   = (({1'b0, evid} >> ev_shift) != 33'd0);
  wire [AW-1:0] ite_addr = itt_base + AW'({evid, 3'b000});

  assign mem_req   = (st == S_MEM);
  assign mem_we    = (step == 3'd7);
  assign mem_wdata = 64'({nicid, SPUR_ID, intid, 2'b11});

  always_comb begin
    case (step)
      3'd0, 3'd1, 3'd2: mem_addr = cmd_base + cmd_off + AW'({step, 3'b000});
      3'd3:             mem_addr = dev_base + AW'({devid, 3'b000});
      3'd5:             mem_addr = coll_base + AW'({oicid, 3'b000});
      3'd6:             mem_addr = coll_base + AW'({nicid, 3'b000});
      default:          mem_addr = ite_addr;
    endcase
  end

  always_comb begin
    code = 4'd0;
    case (step)
      3'd2: if (devid >= dev_entries) code = 4'd1;
      3'd3: if (!dte_v) code = 4'd2;
            else if (ev_bad) code = 4'd3;
      3'd4: if (!ite_v) code = 4'd4;
            else if ({1'b0, oicid} >= coll_entries) code = 4'd5;
            else if ({1'b0, nicid} >= coll_entries) code = 4'd6;
      3'd5: if (!octe_v) code = 4'd7;
      3'd6: if (!ncte_v) code = 4'd8;
            else if ({1'b0, otgt} >= cpu_count) code = 4'd9;
            else if ({1'b0, ntgt} >= cpu_count) code = 4'd10;
      default: code = 4'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      step <= '0;
      devid <= '0; evid <= '0; nicid <= '0; oicid <= '0;
      dte_v <= 1'b0; ite_v <= 1'b0; octe_v <= 1'b0; ncte_v <= 1'b0;
      dte_size <= '0; itt_base <= '0; intid <= '0; otgt <= '0; ntgt <= '0;
      mv_valid <= 1'b0; mv_from <= '0; mv_to <= '0; mv_intid <= '0;
      done <= 1'b0; stall <= 1'b0; err_valid <= 1'b0; err_code <= '0;
    end else begin
      done <= 1'b0;
      err_valid <= 1'b0;
      mv_valid <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st <= S_MEM;
          step <= '0;
        end
        S_MEM: if (mem_ack) begin
          if (mem_err || step == 3'd7) begin
            st <= S_IDLE;
            done <= 1'b1;
            stall <= mem_err;
          end else begin
            st <= S_EVAL;
            case (step)
              3'd0: devid <= mem_rdata[63:32];
              3'd1: evid <= mem_rdata[31:0];
              3'd2: nicid <= mem_rdata[CIDW-1:0];
              3'd3: begin
                dte_v <= mem_rdata[0];
                dte_size <= mem_rdata[5:1];
                itt_base <= mem_rdata[32 +: AW];
              end
              3'd4: begin
                ite_v <= mem_rdata[0];
                intid <= mem_rdata[2 +: INTW];
                oicid <= mem_rdata[IC_LO +: CIDW];
              end
              3'd5: begin
                octe_v <= mem_rdata[0];
                otgt <= mem_rdata[1 +: PNW];
              end
              default: begin
                ncte_v <= mem_rdata[0];
                ntgt <= mem_rdata[1 +: PNW];
              end
            endcase
          end
        end
        default: begin
          if (code != 4'd0) begin
            st <= S_IDLE;
            done <= 1'b1;
            stall <= 1'b0;
            err_valid <= 1'b1;
            err_code <= code;
          end else begin
            st <= S_MEM;
            step <= step + 3'd1;
            if (step == 3'd6 && otgt != ntgt) begin
              mv_valid <= 1'b1;
              mv_from <= otgt;
              mv_to <= ntgt;
              mv_intid <= intid;
            end
          end
        end
      endcase
    end
  end
endmodule

module intr_move_exec_chk #(
  parameter int AW  = 32,
  parameter int PNW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mem_req,
  input logic           mem_we,
  input logic [AW-1:0]  mem_addr,
  input logic           mem_ack,
  input logic           mem_err,
  input logic           mv_valid,
  input logic [PNW-1:0] mv_from,
  input logic [PNW-1:0] mv_to,
  input logic           done,
  input logic           stall,
  input logic           err_valid,
  input logic [3:0]     err_code
);
  // R13
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  err_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && mem_err |=> done && stall);

  // R9
  move_differs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mv_valid |-> mv_from != mv_to);

  // R9
  write_after_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mv_valid |-> mem_req && mem_we);

  // R8
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> done && !stall && !mem_req && !mv_valid && err_code != 4'd0);

  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);
endmodule

bind intr_move_exec intr_move_exec_chk #(.AW(AW), .PNW(PNW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_err(mem_err),
  .mv_valid(mv_valid), .mv_from(mv_from), .mv_to(mv_to),
  .done(done), .stall(stall), .err_valid(err_valid), .err_code(err_code)
);

// File: tb/sim_intr_move_exec.sv
module sim_intr_move_exec;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] cmd_base = 32'h0;
  logic [31:0] cmd_off = 32'h0;
  logic [31:0] dev_base = 32'h100;
  logic [31:0] coll_base = 32'h200;
  logic [31:0] dev_entries = 32'd4;
  logic [16:0] coll_entries = 17'd8;
  logic [16:0] cpu_count = 17'd4;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic        mem_err = 1'b0;
  logic [63:0] mem_rdata = 64'h0;
  logic        mv_valid;
  logic [15:0] mv_from, mv_to, mv_intid;
  logic        done, stall, err_valid;
  logic [3:0]  err_code;

  intr_move_exec u0 (.*);

  always #(CLK_NS/2) clk = ~clk;

  logic [63:0] mem [0:255];
  int          err_mode = 0;
  logic [31:0] err_addr = 32'h0;
  int          wr_cnt = 0, mv_cnt = 0;
  logic [15:0] last_from, last_to, last_intid;
  int          checks = 0, fails = 0;

  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      logic bad;
      bad = (mem_addr == err_addr) && (err_mode == 1 || (err_mode == 2 && mem_we));
      mem_ack <= 1'b1;
      mem_err <= bad;
      mem_rdata <= mem[mem_addr[10:3]];
      if (mem_we && !bad) begin
        mem[mem_addr[10:3]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end
    end else begin
      mem_ack <= 1'b0;
      mem_err <= 1'b0;
    end
    if (mv_valid) begin
      mv_cnt <= mv_cnt + 1;
      last_from <= mv_from;
      last_to <= mv_to;
      last_intid <= mv_intid;
    end
  end

  function automatic logic [63:0] mk_ite(input logic v, input logic [15:0] icid, input logic [15:0] iid);
    return (64'(icid) << 34) | (64'(iid) << 2) | 64'h2 | 64'(v);
  endfunction

  function automatic logic [63:0] exp_ite(input logic [15:0] icid, input logic [15:0] iid);
    return (64'(icid) << 34) | (64'd1023 << 18) | (64'(iid) << 2) | 64'h3;
  endfunction

  function automatic logic [63:0] mk_cte(input logic v, input logic [15:0] tgt);
    return (64'(tgt) << 1) | 64'(v);
  endfunction

  task automatic chk(input logic ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  logic       r_stall, r_errv;
  logic [3:0] r_code;
  int         r_mv, r_wr;

  task automatic setup();
    for (int i = 0; i < 256; i++) mem[i] = 64'h0;
    err_mode = 0;
    mem[0] = {32'd2, 32'd0};
    mem[1] = 64'd1;
    mem[2] = 64'd5;
    mem[34] = (64'h300 << 32) | (64'd3 << 1) | 64'd1;
    mem[97] = mk_ite(1'b1, 16'd3, 16'h2A);
    mem[67] = mk_cte(1'b1, 16'd1);
    mem[69] = mk_cte(1'b1, 16'd2);
  endtask

  task automatic run_cmd(input logic [31:0] off);
    int mv0, wr0, n;
    cmd_off = off;
    mv0 = mv_cnt;
    wr0 = wr_cnt;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(done, "R12 done never seen", 0, 1);
    r_stall = stall;
    r_errv = err_valid;
    r_code = err_code;
    @(negedge clk);
    r_mv = mv_cnt - mv0;
    r_wr = wr_cnt - wr0;
  endtask

  task automatic expect_reject(input logic [3:0] c, input string tag);
    run_cmd(0);
    chk(r_errv && !r_stall, {tag, " reject continue"}, {r_errv, r_stall}, 2'b10);
    chk(r_code == c, {tag, " reason"}, r_code, c);
    chk(r_wr == 0 && r_mv == 0, {tag, " R8 no side effect"}, r_wr + r_mv, 0);
  endtask

  task automatic t_reset();
    chk(!done && !err_valid && !mv_valid && !mem_req, "R14 reset outputs",
        {done, err_valid, mv_valid, mem_req}, 0);
  endtask

  task automatic t_move();
    setup();
    run_cmd(0);
    chk(done == 1'b0, "R12 done one cycle", done, 0);
    chk(!r_stall && !r_errv, "R12 continue", {r_stall, r_errv}, 0);
    chk(r_mv == 1, "R9 move count", r_mv, 1);
    chk(last_from == 1 && last_to == 2, "R9 targets", {last_from, last_to}, {16'd1, 16'd2});
    chk(last_intid == 16'h2A, "R9 intid", last_intid, 16'h2A);
    chk(r_wr == 1, "R11 one write", r_wr, 1);
    chk(mem[97] == exp_ite(16'd5, 16'h2A), "R11 entry", mem[97], exp_ite(16'd5, 16'h2A));
  endtask

  task automatic t_same();
    setup();
    mem[69] = mk_cte(1'b1, 16'd1);
    run_cmd(0);
    chk(r_mv == 0, "R10 no move", r_mv, 0);
    chk(!r_stall && r_wr == 1, "R10 still written", r_wr, 1);
    chk(mem[97] == exp_ite(16'd5, 16'h2A), "R10 entry", mem[97], exp_ite(16'd5, 16'h2A));
  endtask

  task automatic t_offset();
    setup();
    mem[0] = 64'h0; mem[1] = 64'h0; mem[2] = 64'h0;
    mem[4] = {32'd1, 32'd0};
    mem[5] = 64'd0;
    mem[6] = 64'd3;
    mem[33] = (64'h380 << 32) | 64'd1;
    mem[112] = mk_ite(1'b1, 16'd5, 16'h11);
    run_cmd(32'h20);
    chk(!r_errv && !r_stall, "R1 offset command accepted", {r_errv, r_stall}, 0);
    chk(r_mv == 1 && last_from == 2 && last_to == 1, "R1 offset targets", {last_from, last_to}, {16'd2, 16'd1});
    chk(mem[112] == exp_ite(16'd3, 16'h11), "R1 offset entry", mem[112], exp_ite(16'd3, 16'h11));
  endtask

  task automatic t_device();
    setup();
    mem[0] = {32'd4, 32'd0};
    expect_reject(4'd1, "R3 devid range");
    chk(mem[97] == mk_ite(1'b1, 16'd3, 16'h2A), "R3 entry unchanged", mem[97], mk_ite(1'b1, 16'd3, 16'h2A));
    setup();
    mem[34] = mem[34] & ~64'd1;
    expect_reject(4'd2, "R3 device invalid");
  endtask

  task automatic t_event();
    setup();
    mem[34] = (64'h300 << 32) | (64'd1 << 1) | 64'd1;
    mem[1] = 64'd4;
    expect_reject(4'd3, "R4 event at limit");
    mem[1] = 64'd3;
    mem[99] = mk_ite(1'b1, 16'd3, 16'h2A);
    run_cmd(0);
    chk(!r_errv && !r_stall && r_wr == 1, "R4 event below limit", {r_errv, r_stall}, 0);
  endtask

  task automatic t_entry();
    setup();
    mem[97] = mk_ite(1'b0, 16'd3, 16'h2A);
    expect_reject(4'd4, "R5 entry invalid");
    setup();
    mem[97] = mk_ite(1'b1, 16'd8, 16'h2A);
    expect_reject(4'd5, "R5 old collection range");
    setup();
    mem[2] = 64'd8;
    expect_reject(4'd6, "R5 new collection range");
  endtask

  task automatic t_coll();
    setup();
    mem[67] = mk_cte(1'b0, 16'd1);
    expect_reject(4'd7, "R6 old collection invalid");
    setup();
    mem[69] = mk_cte(1'b0, 16'd2);
    expect_reject(4'd8, "R6 new collection invalid");
    setup();
    mem[67] = mk_cte(1'b1, 16'd4);
    expect_reject(4'd9, "R6 old target range");
    setup();
    mem[69] = mk_cte(1'b1, 16'd4);
    expect_reject(4'd10, "R6 new target range");
  endtask

  task automatic t_order();
    setup();
    mem[34] = mem[34] & ~64'd1;
    mem[1] = 64'd99;
    expect_reject(4'd2, "R7 device before event");
    setup();
    mem[97] = mk_ite(1'b0, 16'd3, 16'h2A);
    mem[2] = 64'd8;
    expect_reject(4'd4, "R7 entry before collection");
    setup();
    mem[67] = mk_cte(1'b0, 16'd1);
    mem[69] = mk_cte(1'b1, 16'd4);
    expect_reject(4'd7, "R7 old valid before new target");
  endtask

  task automatic t_memerr();
    setup();
    err_mode = 1; err_addr = 32'h8;
    run_cmd(0);
    chk(r_stall && !r_errv, "R2 command fetch error", {r_stall, r_errv}, 2'b10);
    chk(r_wr == 0 && r_mv == 0, "R2 no effect after fetch error", r_wr + r_mv, 0);
    setup();
    err_mode = 1; err_addr = 32'h110;
    run_cmd(0);
    chk(r_stall && r_wr == 0, "R2 table read error", {r_stall, r_wr[0]}, 2'b10);
    setup();
    err_mode = 2; err_addr = 32'h308;
    run_cmd(0);
    chk(r_stall, "R2 write error stalls", r_stall, 1);
    chk(mem[97] == mk_ite(1'b1, 16'd3, 16'h2A), "R2 failed write keeps entry", mem[97], mk_ite(1'b1, 16'd3, 16'h2A));
  endtask

  initial begin
    #(CLK_NS * 190000);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    setup();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_move();
    t_same();
    t_offset();
    t_device();
    t_event();
    t_entry();
    t_coll();
    t_order();
    t_memerr();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule